// File: doc/BRIEF.md
# Bit-Serial Register Access Slave

This block is the device-side end of a slow four-wire register bus that a host drives by toggling general-purpose pins in software. A rising edge on the host's clear line opens a new frame. The host then shifts in an eight-bit header that carries a read flag and a seven-bit register address. A sixteen-bit data phase follows. In a write, the host shifts the data in. In a read, the block shifts the register value out on its own output pin.

All host pins are asynchronous to the block's fast system clock. They pass through two-flop synchronizers, and their edges are found in the system-clock domain. The host must therefore hold each strobe level for at least three system clocks.

Behind the frame engine sits a small register bank:
- an identity word, read-only;
- a firmware-version word, read-only;
- function-enable words, read/write;
- GPIO-enable words, read/write;
- GPIO-direction words, read/write.

Each address has its own read and write permission. The read/write words drive the block's output vectors.

Top module: `sbus_slave`

## Requirements
- R1: A rising edge on `host_clr` aborts any partial frame and restarts the bit count. While `host_clr` is low, strobe edges are ignored.
- R2: The header is 8 bits, most significant first, captured on strobe rising edges. Bit 7 is the read flag (1 = read, 0 = write). Bits 6..0 are the register address.
- R3: In a write, 16 data bits follow, most significant first. The value is committed only when the 16th bit is captured.
- R4: In a read, each data-phase strobe rising edge puts the next bit on `host_dout`, starting with bit 15. The bit holds until the next strobe rising edge or clear edge.
- R5: Address 0 (identity) reads as `{PLAT_HI, 8'h01}`, with manufacturer code 0x01 in bits 7..0. With the default parameters it reads 0x0001.
- R6: Address 1 reads as the `FW_VERSION` parameter. Its layout is build[15:12], major[11:8], minor[7:4], patch[3:0], and the default has major = 0.
- R7: Writes to addresses 0 and 1 are discarded, and those words keep their values.
- R8: Addresses 10..127 read as 0x0000, and writes to them change nothing.
- R9: The read/write words reset to 0 and map to the outputs as follows:
  - `func_en_o` is {addr3, addr2};
  - `gpio_en_o` is {addr6, addr5, addr4};
  - `gpio_dir_o` is {addr9, addr8, addr7}.
- R10: A write frame cut short by a new clear edge has no effect on any register.
- R11: Strobe edges after the 24th bit of a frame are ignored until the next clear edge. `host_dout` keeps its last bit, and no second write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| host_clr | input | 1 | Asynchronous frame clear; a rising edge starts a frame |
| host_stb | input | 1 | Asynchronous bit strobe |
| host_din | input | 1 | Asynchronous serial data from the host |
| host_dout | output | 1 | Serial read data to the host |
| func_en_o | output | 32 | Function-enable words |
| gpio_en_o | output | 48 | GPIO-enable words |
| gpio_dir_o | output | 48 | GPIO-direction words |

## Verification
The bench targets the following corner cases:
- **Writes to read-only and unmapped addresses.** A design without permission checks would overwrite the identity or version word, or alias an out-of-range address onto a storage word.
- **Write frame aborted after ten data bits.** A design that commits early, or that does not reset its counter on clear, would leave a partial value behind.
- **Strobes while clear is low, and extra strobes after a complete frame.** A counter without gating or saturation would wrap and perform a stray write.
- **Serial read-out.** The bench samples `host_dout` only after each falling strobe edge. A design that launches bits late, or that emits bit 14 first, returns a shifted word.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 16;
    localparam int HDR_W      = ADDR_W + 1;
    localparam int FRAME_BITS = HDR_W + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [7:0] MFR_CODE = 8'h01;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [HDR_W-1:0]  hdr;
        logic [DATA_W-1:0] sh;
        logic              dout;
    } frame_t;
endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o
);
    logic [STAGES-1:0][W-1:0] pipe_q, pipe_d;
    logic [W-1:0]             prev_q, prev_d;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) pipe_d[s] = pipe_q[s-1];
        prev_d = pipe_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
            prev_q <= '0;
        end else begin
            pipe_q <= pipe_d;
            prev_q <= prev_d;
        end
    end

    assign level_o = pipe_q[STAGES-1];
    assign rise_o  = pipe_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sbus_frame.sv
module sbus_frame
    import sbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_lvl,
    input  logic              clr_rise,
    input  logic              stb_rise,
    input  logic              din,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              dout
);
    localparam logic [CNT_W-1:0] HDR_END  = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] DONE     = CNT_W'(FRAME_BITS);

    frame_t f_q, f_d;
    logic   take;
    logic   is_rd;

    assign is_rd = f_q.hdr[HDR_W-1];
    assign take  = stb_rise && clr_lvl && !clr_rise && (f_q.cnt != DONE);

    always_comb begin
        f_d     = f_q;
        wr_en   = 1'b0;
        wr_data = {f_q.sh[DATA_W-2:0], din};
        if (clr_rise) begin
            f_d.cnt  = '0;
            f_d.dout = 1'b0;
        end else if (take) begin
            f_d.cnt = f_q.cnt + 1'b1;
            if (f_q.cnt < HDR_END) begin
                f_d.hdr = {f_q.hdr[HDR_W-2:0], din};
            end else if (is_rd) begin
                if (f_q.cnt == HDR_END) begin
                    f_d.dout = rd_data[DATA_W-1];
                    f_d.sh   = {rd_data[DATA_W-2:0], 1'b0};
                end else begin
                    f_d.dout = f_q.sh[DATA_W-1];
                    f_d.sh   = {f_q.sh[DATA_W-2:0], 1'b0};
                end
            end else begin
                f_d.sh = {f_q.sh[DATA_W-2:0], din};
                wr_en  = (f_q.cnt == LAST_BIT);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign addr_o = f_q.hdr[ADDR_W-1:0];
    assign dout   = f_q.dout;

    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= DONE);
    p_clr_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rise |=> (f_q.cnt == '0));
    p_dout_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb_rise || clr_rise) |=> $stable(f_q.dout));
endmodule

// File: rtl/sbus_regbank.sv
module sbus_regbank
    import sbus_pkg::*;
#(
    parameter int          N_FUNC     = 2,
    parameter int          N_GPEN     = 3,
    parameter int          N_GPDIR    = 3,
    parameter logic [15:0] FW_VERSION = 16'h3012,
    parameter logic [7:0]  PLAT_HI    = 8'h00
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [N_FUNC*DATA_W-1:0]     func_en_o,
    output logic [N_GPEN*DATA_W-1:0]     gpio_en_o,
    output logic [N_GPDIR*DATA_W-1:0]    gpio_dir_o
);
    localparam int N_WR  = N_FUNC + N_GPEN + N_GPDIR;
    localparam int IDX_W = (N_WR > 1) ? $clog2(N_WR) : 1;
    localparam logic [ADDR_W-1:0] A_ID     = '0;
    localparam logic [ADDR_W-1:0] A_FW     = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] WR_FIRST = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] WR_LAST  = ADDR_W'(2 + N_WR - 1);

    logic [N_WR-1:0][DATA_W-1:0] store_q, store_d;
    logic                        in_wr;
    logic [ADDR_W-1:0]           off;

    assign in_wr = (addr >= WR_FIRST) && (addr <= WR_LAST);
    assign off   = addr - WR_FIRST;

    always_comb begin
        store_d = store_q;
        if (we && in_wr) store_d[off[IDX_W-1:0]] = wdata;
        if (addr == A_ID)      rdata = {PLAT_HI, MFR_CODE};
        else if (addr == A_FW) rdata = FW_VERSION;
        else if (in_wr)        rdata = store_q[off[IDX_W-1:0]];
        else                   rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) store_q <= '0;
        else        store_q <= store_d;
    end

    assign func_en_o  = store_q[N_FUNC-1:0];
    assign gpio_en_o  = store_q[N_FUNC+N_GPEN-1:N_FUNC];
    assign gpio_dir_o = store_q[N_WR-1:N_FUNC+N_GPEN];

    p_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !in_wr) |=> $stable(store_q));
endmodule

// File: rtl/sbus_slave.sv
module sbus_slave
    import sbus_pkg::*;
#(
    parameter int          N_FUNC      = 2,
    parameter int          N_GPEN      = 3,
    parameter int          N_GPDIR     = 3,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] FW_VERSION  = 16'h3012,
    parameter logic [7:0]  PLAT_HI     = 8'h00
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_clr,
    input  logic                      host_stb,
    input  logic                      host_din,
    output logic                      host_dout,
    output logic [N_FUNC*DATA_W-1:0]  func_en_o,
    output logic [N_GPEN*DATA_W-1:0]  gpio_en_o,
    output logic [N_GPDIR*DATA_W-1:0] gpio_dir_o
);
    logic [2:0]        lvl, rise;
    logic [ADDR_W-1:0] addr;
    logic              we;
    logic [DATA_W-1:0] wdata, rdata;

    sbus_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({host_clr, host_stb, host_din}),
        .level_o(lvl), .rise_o(rise)
    );

    sbus_frame u_frame (
        .clk(clk), .rst_n(rst_n),
        .clr_lvl(lvl[2]), .clr_rise(rise[2]), .stb_rise(rise[1]),
        .din(lvl[0]), .rd_data(rdata),
        .addr_o(addr), .wr_en(we), .wr_data(wdata), .dout(host_dout)
    );

    sbus_regbank #(
        .N_FUNC(N_FUNC), .N_GPEN(N_GPEN), .N_GPDIR(N_GPDIR),
        .FW_VERSION(FW_VERSION), .PLAT_HI(PLAT_HI)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
        .func_en_o(func_en_o), .gpio_en_o(gpio_en_o), .gpio_dir_o(gpio_dir_o)
    );

    p_no_write_clr_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl[2] |-> !we);
endmodule

// File: tb/sbus_slave_test.sv
module sbus_slave_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_clr = 1'b0, host_stb = 1'b0, host_din = 1'b0;
    logic host_dout;
    logic [31:0] func_en_o;
    logic [47:0] gpio_en_o, gpio_dir_o;

    localparam int H = 5;
    localparam logic [15:0] FW = 16'h3012;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sbus_slave uut (
        .clk(clk), .rst_n(rst_n), .host_clr(host_clr), .host_stb(host_stb),
        .host_din(host_din), .host_dout(host_dout), .func_en_o(func_en_o),
        .gpio_en_o(gpio_en_o), .gpio_dir_o(gpio_dir_o)
    );

    // {read, addr[6:0], data[15:0]}: for reads, data is the expected word
    localparam int NV = 14;
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 7'd2,  16'hA5C3},
        {1'b1, 7'd2,  16'hA5C3},
        {1'b0, 7'd9,  16'h1234},
        {1'b1, 7'd9,  16'h1234},
        {1'b0, 7'd0,  16'hFFFF},
        {1'b1, 7'd0,  16'h0001},
        {1'b1, 7'd1,  FW},
        {1'b0, 7'd1,  16'h0F0F},
        {1'b1, 7'd1,  FW},
        {1'b0, 7'd64, 16'hBEEF},
        {1'b1, 7'd64, 16'h0000},
        {1'b0, 7'd4,  16'h8001},
        {1'b1, 7'd4,  16'h8001},
        {1'b1, 7'd10, 16'h0000}
    };

    task automatic check(string req, logic [47:0] act, logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (H) @(negedge clk);
    endtask

    task automatic start();
        host_clr = 1'b0; hold();
        host_clr = 1'b1; hold();
    endtask

    task automatic send_hdr(logic rd, logic [6:0] a);
        logic [7:0] h = {rd, a};
        for (int i = 7; i >= 0; i--) begin
            host_stb = 1'b0; host_din = h[i]; hold();
            host_stb = 1'b1; hold();
        end
        host_stb = 1'b0; hold();
    endtask

    task automatic do_write(logic [6:0] a, logic [15:0] d);
        start();
        send_hdr(1'b0, a);
        for (int i = 15; i >= 0; i--) begin
            host_din = d[i];
            host_stb = 1'b1; hold();
            host_stb = 1'b0; hold();
        end
        host_stb = 1'b1; hold();
    endtask

    task automatic do_read(logic [6:0] a, output logic [15:0] d);
        start();
        send_hdr(1'b1, a);
        d = '0;
        for (int i = 15; i >= 0; i--) begin
            host_stb = 1'b1; hold();
            host_stb = 1'b0; hold();
            d[i] = host_dout;
        end
        host_stb = 1'b1; hold();
    endtask

    initial begin
        logic [15:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R9 reset state
        check("R9 reset func_en", {16'h0, func_en_o}, 48'h0);
        check("R9 reset gpio_en", gpio_en_o, 48'h0);
        check("R9 reset gpio_dir", gpio_dir_o, 48'h0);
        check("R4 reset dout", {47'h0, host_dout}, 48'h0);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][23]) begin
                do_read(VEC[v][22:16], rd);
                check($sformatf("R2/R4/R5/R6/R8 read vec %0d", v), {32'h0, rd}, {32'h0, VEC[v][15:0]});
            end else begin
                do_write(VEC[v][22:16], VEC[v][15:0]);
            end
        end

        // R3/R9 mapping of committed writes to output vectors
        check("R3 R9 func_en", {16'h0, func_en_o}, {32'h0, 16'hA5C3});
        check("R9 gpio_dir word 9", {32'h0, gpio_dir_o[47:32]}, {32'h0, 16'h1234});
        check("R9 gpio_en word 4", {32'h0, gpio_en_o[15:0]}, {32'h0, 16'h8001});
        check("R7 R8 no stray writes gpio_en", {16'h0, gpio_en_o[47:16]}, 48'h0);

        // R10: write to addr 3 aborted after 10 data bits
        start();
        send_hdr(1'b0, 7'd3);
        for (int i = 0; i < 10; i++) begin
            host_din = 1'b1;
            host_stb = 1'b1; hold();
            host_stb = 1'b0; hold();
        end
        start();
        host_stb = 1'b1; hold();
        check("R10 aborted frame no effect", {32'h0, func_en_o[31:16]}, 48'h0);
        do_read(7'd3, rd);
        check("R10 aborted frame readback", {32'h0, rd}, 48'h0);
        check("R1 counter restarted after abort", {32'h0, rd}, 48'h0);

        // R1: strobes while clear is low are ignored (addr 3 write pattern)
        host_clr = 1'b0; hold();
        for (int i = 23; i >= 0; i--) begin
            host_stb = 1'b0; host_din = (24'h03FFFF >> i) & 1; hold();
            host_stb = 1'b1; hold();
        end
        check("R1 strobes ignored while clear low", {32'h0, func_en_o[31:16]}, 48'h0);

        // R11: extra strobes after a complete write frame
        do_write(7'd5, 16'h00FF);
        for (int i = 0; i < 20; i++) begin
            host_stb = 1'b0; host_din = 1'b1; hold();
            host_stb = 1'b1; hold();
        end
        check("R11 extra strobes no second write", {32'h0, gpio_en_o[31:16]}, {32'h0, 16'h00FF});

        // R11: dout holds last bit after extra strobes in a read
        do_read(7'd5, rd);
        check("R4 read word 5", {32'h0, rd}, {32'h0, 16'h00FF});
        host_stb = 1'b0; hold();
        host_stb = 1'b1; hold();
        host_stb = 1'b0; hold();
        check("R11 dout holds bit 0", {47'h0, host_dout}, 48'h1);

        // R4: single read with MSB-only pattern
        do_write(7'd7, 16'h8000);
        do_read(7'd7, rd);
        check("R4 MSB first", {32'h0, rd}, {32'h0, 16'h8000});

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule